// File: doc/BRIEF.md
# Bridge Command Packet Receiver

This block sits behind the bulk-out endpoint of a host-to-serial bridge. Each host command arrives as a byte stream with a start marker and an end marker. The block decodes the 16-bit command identifier and checks the counts carried in the header. It writes transfer payload straight into a shared transfer buffer. At the end of every packet it settles the bridge mode register, the stored status code and the select line. The response builder and the serial engine follow that mode register and the one-cycle request pulses.

A serial transfer can span several packets. The first packet declares the write and read lengths, and continuation packets append further payload. The serial engine gets its start pulse only once the declared number of write bytes has arrived. If a packet carries too many bytes, the excess is dropped and an overflow status is reported. A read length of all ones means full duplex, and the read length then equals the write length.

Byte input is valid/ready. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for exactly one cycle, the cycle after the byte marked `in_last` is accepted. The block decides the packet's outcome in that cycle. The source must hold its byte and valid through that cycle. There is no other back-pressure.

Top module: `cmd_pkt_rx`

## Requirements
- R1: A byte is taken on an edge where in_valid and in_ready are both high. in_ready drops for the single cycle after a taken byte with in_last, and is high otherwise. A taken byte with in_sop restarts the packet at byte position 0. After an end-of-packet the next byte is also position 0.
- R2: Bytes 0 (low) and 1 (high) hold the identifier, little-endian: 0x0000 configuration request, 0x0001 transfer start, 0x0002 transfer continuation, 0x0003 select control, 0x0004 response restart. A packet of fewer than 2 bytes gives status 5 (unexpected) and mode 4.
- R3: A transfer start carries the write count in bytes 2-3 and the read count in bytes 4-5, both little-endian, with payload from byte 6. A start shorter than 6 bytes, or a continuation or select packet shorter than 4 bytes, gives status 5 and mode 4.
- R4: A transfer start is rejected with mode 4 and no buffer write. The status is 1 when bridge_en is low. Otherwise it is 2 when the write count exceeds MAX_WR. Otherwise it is 3 when the read count exceeds MAX_RD and is not 0xFFFF. The checks are applied in that order.
- R5: An accepted start resets the write index to 0 and takes the write count as the declared size. Each payload byte is written at the current index, and the index then advances. A byte arriving when the index equals the size is not written and raises status 4 (overflow) with mode 4.
- R6: After a successful start or continuation, if the index equals the size, the mode becomes 3 and start_xfer pulses for one cycle with status 0. Otherwise the mode becomes 0 (idle) with status 0. The lengths are latched from the start packet. A read count of 0xFFFF sets xfer_duplex and makes xfer_rd_len equal to the write count.
- R7: A continuation carries payload from byte 4. Its payload is written only while the stored status is 0. Otherwise nothing is written, the status is kept and the mode becomes 4.
- R8: A select-control packet takes bit 0 of byte 2 as the select flag. A flag of 1 drives spi_cs_n low, and a flag of 0 drives it high. The mode becomes 2, cs_req pulses and the status is kept.
- R9: A configuration request sets mode 1 and pulses cfg_req, and the status is kept.
- R10: A response restart sets mode 4 and keeps the stored status, with no start pulse and no buffer write.
- R11: Any other identifier gives status 5 and mode 4.
- R12: After reset the mode is 0, the status is 0, spi_cs_n is high, in_ready is high and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridge_en | input | 1 | Combined bridge enable |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte ready |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_last | input | 1 | Last byte of a packet |
| buf_we | output | 1 | Transfer buffer write strobe |
| buf_addr | output | IDX_W | Transfer buffer byte address |
| buf_data | output | 8 | Transfer buffer write byte |
| mode | output | 3 | Bridge mode: 0 idle, 1 send config, 2 send select ack, 3 run serial, 4 first response, 5 further response |
| status | output | 16 | Stored status code |
| start_xfer | output | 1 | One-cycle serial transfer start |
| cfg_req | output | 1 | One-cycle configuration response request |
| cs_req | output | 1 | One-cycle select acknowledgement request |
| spi_cs_n | output | 1 | Active-low select line |
| xfer_wr_len | output | LEN_W | Latched write length |
| xfer_rd_len | output | LEN_W | Latched read length |
| xfer_duplex | output | 1 | Full-duplex transfer flag |

## Verification
Some behaviours are checked by assertions on every cycle. in_ready must drop after an end-of-packet. The write index must never pass the declared size, and an overflow must leave the index at that size. start_xfer may only appear with the run-serial mode and a clean status. The request pulses may never coincide, and the select line may change only with a select acknowledgement. Other behaviours can only be shown by the bench scenarios. These are the error priority among disabled, bad write count and bad read count; the exact bytes that reach the buffer across a start plus a continuation; dropped continuation payload after an error; and the full-duplex length substitution.

// File: rtl/cmd_pkt_rx_pkg.sv
package cmd_pkt_rx_pkg;
  typedef enum logic [2:0] {
    MD_IDLE       = 3'd0,
    MD_SEND_CFG   = 3'd1,
    MD_SEND_CS    = 3'd2,
    MD_RUN_SPI    = 3'd3,
    MD_RESP_FIRST = 3'd4,
    MD_RESP_MORE  = 3'd5
  } mode_e;

  localparam logic [15:0] ST_OK     = 16'd0;
  localparam logic [15:0] ST_OFF    = 16'd1;
  localparam logic [15:0] ST_WR_BAD = 16'd2;
  localparam logic [15:0] ST_RD_BAD = 16'd3;
  localparam logic [15:0] ST_OVF    = 16'd4;
  localparam logic [15:0] ST_UNEXP  = 16'd5;

  localparam logic [15:0] PID_CFG     = 16'h0000;
  localparam logic [15:0] PID_START   = 16'h0001;
  localparam logic [15:0] PID_CONT    = 16'h0002;
  localparam logic [15:0] PID_CS      = 16'h0003;
  localparam logic [15:0] PID_RESTART = 16'h0004;

  localparam logic [15:0] RD_DUPLEX = 16'hFFFF;
endpackage

// File: rtl/cmd_pkt_rx_hdr.sv
module cmd_pkt_rx_hdr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        sop,
  input  logic        done,
  input  logic [7:0]  data,
  output logic [2:0]  pos,
  output logic [2:0]  seen,
  output logic [15:0] pid,
  output logic [15:0] f1,
  output logic [15:0] f2
);
  logic [2:0] seen_q;

  assign pos  = sop ? 3'd0 : seen_q;
  assign seen = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 3'd0;
      pid    <= 16'd0;
      f1     <= 16'd0;
      f2     <= 16'd0;
    end else if (done) begin
      seen_q <= 3'd0;
    end else if (acc) begin
      seen_q <= (pos == 3'd7) ? 3'd7 : pos + 3'd1;
      case (pos)
        3'd0: begin
          pid <= {8'h00, data};
          f1  <= 16'd0;
          f2  <= 16'd0;
        end
        3'd1: pid[15:8] <= data;
        3'd2: f1[7:0]   <= data;
        3'd3: f1[15:8]  <= data;
        3'd4: f2[7:0]   <= data;
        3'd5: f2[15:8]  <= data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_pkt_rx_wr.sv
module cmd_pkt_rx_wr #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_size,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic             clr,
  output logic             we,
  output logic [IDX_W-1:0] addr,
  output logic [7:0]       wdata,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] size,
  output logic             ovf
);
  assign we    = take && (idx < size);
  assign addr  = idx;
  assign wdata = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      size <= '0;
      ovf  <= 1'b0;
    end else if (load) begin
      idx  <= '0;
      size <= load_size;
      ovf  <= 1'b0;
    end else begin
      if (clr) ovf <= 1'b0;
      if (take) begin
        if (idx < size) idx <= idx + 1'b1;
        else            ovf <= 1'b1;
      end
    end
  end

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= size);
  assert_ovf_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (idx == size));
endmodule

// File: rtl/cmd_pkt_rx_verdict.sv
module cmd_pkt_rx_verdict
  import cmd_pkt_rx_pkg::*;
#(
  parameter int MAX_WR = 1022,
  parameter int MAX_RD = 1022
) (
  input  logic [2:0]  seen,
  input  logic [15:0] pid,
  input  logic [15:0] f1,
  input  logic [15:0] f2,
  input  logic        en,
  input  logic [15:0] st,
  input  logic        ovf,
  input  logic        idx_eq,
  output mode_e       nx_mode,
  output logic [15:0] nx_st,
  output logic        go_spi,
  output logic        go_cfg,
  output logic        go_cs,
  output logic        take_len
);
  localparam logic [15:0] WR_LIM = 16'(MAX_WR);
  localparam logic [15:0] RD_LIM = 16'(MAX_RD);

  always_comb begin
    nx_mode  = MD_RESP_FIRST;
    nx_st    = ST_UNEXP;
    go_spi   = 1'b0;
    go_cfg   = 1'b0;
    go_cs    = 1'b0;
    take_len = 1'b0;
    if (seen >= 3'd2) begin
      case (pid)
        PID_CFG: begin
          nx_mode = MD_SEND_CFG;
          nx_st   = st;
          go_cfg  = 1'b1;
        end
        PID_RESTART: nx_st = st;
        PID_CS: if (seen >= 3'd4) begin
          nx_mode = MD_SEND_CS;
          nx_st   = st;
          go_cs   = 1'b1;
        end
        PID_START: if (seen >= 3'd6) begin
          if (!en)                                  nx_st = ST_OFF;
          else if (f1 > WR_LIM)                     nx_st = ST_WR_BAD;
          else if (f2 > RD_LIM && f2 != RD_DUPLEX)  nx_st = ST_RD_BAD;
          else if (ovf)                             nx_st = ST_OVF;
          else begin
            nx_st    = ST_OK;
            take_len = 1'b1;
            if (idx_eq) begin
              nx_mode = MD_RUN_SPI;
              go_spi  = 1'b1;
            end else begin
              nx_mode = MD_IDLE;
            end
          end
        end
        PID_CONT: if (seen >= 3'd4) begin
          if (st != ST_OK)  nx_st = st;
          else if (ovf)     nx_st = ST_OVF;
          else begin
            nx_st = ST_OK;
            if (idx_eq) begin
              nx_mode = MD_RUN_SPI;
              go_spi  = 1'b1;
            end else begin
              nx_mode = MD_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx
  import cmd_pkt_rx_pkg::*;
#(
  parameter int MAX_WR = 1022,
  parameter int MAX_RD = 1022,
  localparam int IDX_W = $clog2(MAX_WR + 1),
  localparam int MAXC  = (MAX_WR > MAX_RD) ? MAX_WR : MAX_RD,
  localparam int LEN_W = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bridge_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_last,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_addr,
  output logic [7:0]       buf_data,
  output logic [2:0]       mode,
  output logic [15:0]      status,
  output logic             start_xfer,
  output logic             cfg_req,
  output logic             cs_req,
  output logic             spi_cs_n,
  output logic [LEN_W-1:0] xfer_wr_len,
  output logic [LEN_W-1:0] xfer_rd_len,
  output logic             xfer_duplex
);
  localparam logic [15:0] WR_LIM = 16'(MAX_WR);
  localparam logic [15:0] RD_LIM = 16'(MAX_RD);

  logic             commit_q;
  logic             acc;
  logic [2:0]       pos, seen;
  logic [15:0]      pid, f1, f2;
  logic [15:0]      status_q;
  mode_e            mode_q;
  logic             cmd_ok, take, load;
  logic [IDX_W-1:0] wr_idx, wr_size;
  logic             ovf;
  mode_e            nx_mode;
  logic [15:0]      nx_st;
  logic             go_spi, go_cfg, go_cs, take_len;

  assign in_ready = !commit_q;
  assign acc      = in_valid && in_ready;
  assign mode     = mode_q;
  assign status   = status_q;

  cmd_pkt_rx_hdr u_hdr (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sop(in_sop), .done(commit_q),
    .data(in_data), .pos(pos), .seen(seen), .pid(pid), .f1(f1), .f2(f2)
  );

  assign cmd_ok = bridge_en && (f1 <= WR_LIM) && ((f2 <= RD_LIM) || (f2 == RD_DUPLEX));
  assign take   = acc && (((pid == PID_START) && (pos >= 3'd6) && cmd_ok) ||
                          ((pid == PID_CONT)  && (pos >= 3'd4) && (status_q == ST_OK)));
  assign load   = acc && (pid == PID_START) && (pos == 3'd5);

  cmd_pkt_rx_wr #(.IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_size(f1[IDX_W-1:0]),
    .take(take), .data(in_data), .clr(acc && (pos == 3'd0)),
    .we(buf_we), .addr(buf_addr), .wdata(buf_data),
    .idx(wr_idx), .size(wr_size), .ovf(ovf)
  );

  cmd_pkt_rx_verdict #(.MAX_WR(MAX_WR), .MAX_RD(MAX_RD)) u_verdict (
    .seen(seen), .pid(pid), .f1(f1), .f2(f2), .en(bridge_en), .st(status_q),
    .ovf(ovf), .idx_eq(wr_idx == wr_size), .nx_mode(nx_mode), .nx_st(nx_st),
    .go_spi(go_spi), .go_cfg(go_cfg), .go_cs(go_cs), .take_len(take_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q    <= 1'b0;
      mode_q      <= MD_IDLE;
      status_q    <= ST_OK;
      start_xfer  <= 1'b0;
      cfg_req     <= 1'b0;
      cs_req      <= 1'b0;
      spi_cs_n    <= 1'b1;
      xfer_wr_len <= '0;
      xfer_rd_len <= '0;
      xfer_duplex <= 1'b0;
    end else begin
      commit_q   <= acc && in_last;
      start_xfer <= 1'b0;
      cfg_req    <= 1'b0;
      cs_req     <= 1'b0;
      if (commit_q) begin
        mode_q     <= nx_mode;
        status_q   <= nx_st;
        start_xfer <= go_spi;
        cfg_req    <= go_cfg;
        cs_req     <= go_cs;
        if (go_cs) spi_cs_n <= ~f1[0];
        if (take_len) begin
          xfer_wr_len <= f1[LEN_W-1:0];
          xfer_duplex <= (f2 == RD_DUPLEX);
          xfer_rd_len <= (f2 == RD_DUPLEX) ? f1[LEN_W-1:0] : f2[LEN_W-1:0];
        end
      end
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_last) |=> !in_ready);
  assert_start_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_xfer |-> (mode_q == MD_RUN_SPI && status_q == ST_OK));
  assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_xfer, cfg_req, cs_req}));
  assert_select_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> cs_req);
endmodule

// File: tb/cmd_pkt_rx_test.sv
`timescale 1ns/1ps
module cmd_pkt_rx_test;
  localparam int MW = 8;
  localparam int MR = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bridge_en = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready, buf_we, start_xfer, cfg_req, cs_req, spi_cs_n, xfer_duplex;
  logic [3:0] buf_addr, xfer_wr_len, xfer_rd_len;
  logic [7:0] buf_data;
  logic [2:0] mode;
  logic [15:0] status;

  int errors = 0;
  int checks = 0;
  int wcount = 0;
  logic [7:0] mem [0:15];
  logic [7:0] pk [0:31];
  int pk_len = 0;

  always #4 clk = ~clk;

  cmd_pkt_rx #(.MAX_WR(MW), .MAX_RD(MR)) uut (
    .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_last(in_last),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .mode(mode),
    .status(status), .start_xfer(start_xfer), .cfg_req(cfg_req), .cs_req(cs_req),
    .spi_cs_n(spi_cs_n), .xfer_wr_len(xfer_wr_len), .xfer_rd_len(xfer_rd_len),
    .xfer_duplex(xfer_duplex)
  );

  always @(posedge clk) if (buf_we) begin
    mem[buf_addr] <= buf_data;
    wcount <= wcount + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int wc, input int k);
    return 8'(wc * 17 + k * 5 + 3);
  endfunction

  task automatic put(input logic [7:0] b, input logic s, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_sop = s; in_last = l;
    @(posedge clk);
  endtask

  task automatic close_pkt();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0;
    chk("R1 ready low after last", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send();
    for (int i = 0; i < pk_len; i++) put(pk[i], i == 0, i == pk_len - 1);
    close_pkt();
  endtask

  task automatic hdr16(input int at, input int v);
    pk[at] = 8'(v); pk[at+1] = 8'(v >> 8);
  endtask

  task automatic expect_out(input string tag, input int md, input int st, input int sx);
    chk({tag, " mode"}, int'(mode), md);
    chk({tag, " status"}, int'(status), st);
    chk({tag, " start"}, int'(start_xfer), sx);
  endtask

  function automatic int rc_of(input int j);
    case (j)
      0: return 0;
      1: return 3;
      2: return MR;
      3: return MR + 1;
      default: return 16'hFFFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 mode", int'(mode), 0);
    chk("R12 status", int'(status), 0);
    chk("R12 cs_n", int'(spi_cs_n), 1);
    chk("R12 ready", int'(in_ready), 1);
    chk("R12 pulses", int'({start_xfer, cfg_req, cs_req}), 0);

    // R2 one-byte packet
    pk[0] = 8'h01; pk_len = 1; send();
    expect_out("R2 short", 4, 5, 0);

    // R8 select low, then high, bit1 only leaves high
    hdr16(0, 3); hdr16(2, 1); pk_len = 4; send();
    chk("R8 cs_n low", int'(spi_cs_n), 0);
    chk("R8 cs_req", int'(cs_req), 1);
    chk("R8 mode", int'(mode), 2);
    chk("R8 status kept", int'(status), 5);
    hdr16(0, 3); hdr16(2, 0); pk_len = 4; send();
    chk("R8 cs_n high", int'(spi_cs_n), 1);
    hdr16(0, 3); hdr16(2, 2); pk_len = 4; send();
    chk("R8 bit1 ignored", int'(spi_cs_n), 1);
    // R3 truncated select leaves line
    hdr16(0, 3); pk[2] = 8'h01; pk_len = 3; send();
    expect_out("R3 short select", 4, 5, 0);
    chk("R3 cs_n unchanged", int'(spi_cs_n), 1);

    // R11 unknown ids, identifier little-endian (R2)
    hdr16(0, 7); pk_len = 2; send();
    expect_out("R11 unknown", 4, 5, 0);
    hdr16(0, 16'h0101); pk_len = 2; send();
    expect_out("R2 high byte decoded", 4, 5, 0);

    // R3 truncated start
    w0 = wcount;
    hdr16(0, 1); hdr16(2, 2); pk[4] = 8'h00; pk_len = 5; send();
    expect_out("R3 short start", 4, 5, 0);
    chk("R3 no writes", wcount - w0, 0);

    // R4 disabled and priority
    bridge_en = 1'b0; w0 = wcount;
    hdr16(0, 1); hdr16(2, 2); hdr16(4, 0); pk[6] = 8'hAA; pk[7] = 8'hBB; pk_len = 8; send();
    expect_out("R4 disabled", 4, 1, 0);
    chk("R4 disabled no writes", wcount - w0, 0);
    hdr16(0, 1); hdr16(2, MW + 1); hdr16(4, MR + 1); pk_len = 6; send();
    expect_out("R4 disabled first", 4, 1, 0);
    bridge_en = 1'b1;
    hdr16(0, 1); hdr16(2, MW + 1); hdr16(4, MR + 1); pk_len = 6; send();
    expect_out("R4 write count first", 4, 2, 0);

    // Sweep: R4 R5 R6 start plus continuation
    for (int wc = 0; wc <= MW + 1; wc++) begin
      for (int j = 0; j < 5; j++) begin
        for (int p1 = 0; p1 <= wc + 1; p1++) begin
          int rc;
          bit ok;
          rc = rc_of(j);
          ok = (wc <= MW) && ((rc <= MR) || (rc == 16'hFFFF));
          w0 = wcount;
          hdr16(0, 1); hdr16(2, wc); hdr16(4, rc);
          for (int k = 0; k < p1; k++) pk[6+k] = pat(wc, k);
          pk_len = 6 + p1;
          send();
          if (wc > MW)      expect_out("R4 wc", 4, 2, 0);
          else if (!ok)     expect_out("R4 rc", 4, 3, 0);
          else if (p1 > wc) expect_out("R5 overflow", 4, 4, 0);
          else if (p1 == wc) expect_out("R6 done in start", 3, 0, 1);
          else              expect_out("R6 waiting", 0, 0, 0);
          if (ok && p1 < wc) begin
            hdr16(0, 2); hdr16(2, p1);
            for (int k = p1; k < wc; k++) pk[4+k-p1] = pat(wc, k);
            pk_len = 4 + wc - p1;
            send();
            expect_out("R6 done in continuation", 3, 0, 1);
          end
          if (ok) begin
            int bad;
            bad = 0;
            for (int k = 0; k < wc; k++) if (mem[k] !== pat(wc, k)) bad++;
            chk("R5 buffer bytes", bad, 0);
            chk("R6 wr_len", int'(xfer_wr_len), wc);
            chk("R6 rd_len", int'(xfer_rd_len), (rc == 16'hFFFF) ? wc : rc);
            chk("R6 duplex", int'(xfer_duplex), (rc == 16'hFFFF) ? 1 : 0);
          end
          chk("R5 write count", wcount - w0, ok ? wc : 0);
        end
      end
    end

    // R7 continuation ignored after overflow
    hdr16(0, 1); hdr16(2, 1); hdr16(4, 0); pk[6] = 8'h11; pk[7] = 8'h22; pk_len = 8; send();
    expect_out("R5 overflow setup", 4, 4, 0);
    w0 = wcount;
    hdr16(0, 2); hdr16(2, 0); pk[4] = 8'h33; pk[5] = 8'h44; pk_len = 6; send();
    expect_out("R7 ignored", 4, 4, 0);
    chk("R7 no writes", wcount - w0, 0);

    // R10 restart keeps status
    hdr16(0, 4); pk_len = 2; send();
    expect_out("R10 restart", 4, 4, 0);
    chk("R10 no writes", wcount - w0, 0);

    // R9 configuration keeps status
    hdr16(0, 0); pk_len = 2; send();
    chk("R9 mode", int'(mode), 1);
    chk("R9 cfg_req", int'(cfg_req), 1);
    chk("R9 status kept", int'(status), 4);

    // R1 start marker restarts a packet midway
    put(8'h03, 1'b1, 1'b0);
    put(8'h00, 1'b0, 1'b0);
    put(8'h04, 1'b1, 1'b0);
    put(8'h00, 1'b0, 1'b1);
    close_pkt();
    expect_out("R1 restart at sop", 4, 4, 0);
    chk("R1 no cs ack", int'(cs_req), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule